// File: doc/BRIEF.md
# Programmable Logic Array with Serial Connection Map

This block is a small array of `N_GATE` output gates fed from `N_IN` shared input columns. Which columns feed which gate is set by a connection map held in registers. The map is written one bit at a time through a synchronous port that carries an address and a data bit. A map bit of 1 attaches its column to the gate as one more gate input. A map bit of 0 leaves the column out.

One parameter picks a single gate function for the whole array: AND, OR, NAND, NOR, XOR or XNOR. A second parameter selects how columns are formed. In plain-column mode each input gives one true column. In paired mode each input gives a true column and, next to it, a column carrying its complement.

The position of each connection bit in the map is `base + input*IN_STEP + gate*GATE_STEP`. The base is `TRUE_BASE` for true columns and `COMP_BASE` for complement columns. Integrators can therefore match the map layout to whatever fuse image they load. Once the map is written, every output is a purely combinational function of the inputs.

Top module: `pla_core`

## Requirements
- R1: An active-low reset clears every connection bit, so each gate shows its empty value (see R8) until a write lands.
- R2: When `wr_en` is high at a rising clock edge and `wr_addr` is below the map depth, `wr_bit` is stored at that address. A stored 1 connects the column addressed there, and a stored 0 disconnects it.
- R3: The true column of input i for gate g lives at address `TRUE_BASE + i*IN_STEP + g*GATE_STEP`. In plain-column mode the defaults are TRUE_BASE 0, IN_STEP 1 and GATE_STEP N_IN. Address 0 is therefore input 0 of gate 0, and the following addresses walk the inputs of gate 0 before moving on to gate 1.
- R4: In paired mode, the complement column of input i for gate g lives at `COMP_BASE + i*IN_STEP + g*GATE_STEP` and carries the inverse of input i. The defaults are TRUE_BASE 0, COMP_BASE 1, IN_STEP 2 and GATE_STEP 2*N_IN, so true and complement columns alternate within each gate.
- R5: With FN_AND, a gate outputs the AND of all its connected column values. FN_NAND outputs the inverse of that AND.
- R6: With FN_OR, a gate outputs the OR of its connected column values. FN_NOR outputs the inverse of that OR.
- R7: With FN_XOR, a gate outputs 1 when an odd number of its connected column values are 1. FN_XNOR outputs the inverse of that.
- R8: A gate with no connected column outputs 1 for AND, 0 for OR and 0 for XOR. Each inverting variant outputs the opposite: NAND 0, NOR 1, XNOR 1.
- R9: A write whose address is at or above the map depth leaves the map unchanged. It raises `wr_err` for exactly the one cycle that follows the write edge.
- R10: Outputs depend combinationally on `a_in`. A change on `a_in` shows on `y_out` without waiting for a clock edge.
- R11: In plain-column OR mode with 3 inputs and 4 gates, the map bits at addresses 0 to 11 are 1,1,1, 0,1,0, 1,0,1, 0,0,1. This yields y[0]=a[0]|a[1]|a[2], y[1]=a[1], y[2]=a[0]|a[2] and y[3]=a[2].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for map writes |
| rst_n | input | 1 | Asynchronous active-low reset, clears the map |
| wr_en | input | 1 | Map write strobe |
| wr_addr | input | ADDR_W | Map bit address |
| wr_bit | input | 1 | Value written to the addressed map bit |
| a_in | input | N_IN | Logic inputs feeding the columns |
| y_out | output | N_GATE | One output per gate |
| wr_err | output | 1 | One-cycle pulse after a write to an address beyond the map |

## Verification
Three configurations are exercised:
- plain-column OR with default mapping,
- paired-column XNOR with default mapping,
- plain-column NAND with a shifted base and a widened gate stride.

Each configuration is loaded with an all-zero map, an all-ones map, the R11 example map and a series of pseudo-random maps. After every load the bench sweeps all eight input values.

The all-zero map separates the empty-gate levels of the three functions. The all-ones map and the random maps show whether each bit lands on the column its address formula names. In particular, they would expose a swapped true/complement slot or a wrong stride. They also show whether the reduction and the inversion are the right ones.

Writes just past the map end, and at the top of the address range, check that the map stays unchanged and that the error pulse lasts one cycle.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the programmable logic array.
// Assumes one gate function per array instance.
package pla_pkg;

    typedef enum logic [2:0] {
        FN_AND  = 3'd0,
        FN_OR   = 3'd1,
        FN_NAND = 3'd2,
        FN_NOR  = 3'd3,
        FN_XOR  = 3'd4,
        FN_XNOR = 3'd5
    } gate_fn_e;

    // True for the variants that invert their base reduction.
    function automatic logic fn_inverts(gate_fn_e f);
        return (f == FN_NAND) || (f == FN_NOR) || (f == FN_XNOR);
    endfunction

    // Output level of a gate with nothing connected.
    function automatic logic empty_level(gate_fn_e f);
        logic base_id;
        base_id = (f == FN_AND) || (f == FN_NAND);
        return base_id ^ fn_inverts(f);
    endfunction

endpackage

// File: rtl/pla_fuse_store.sv
`timescale 1ns/1ps
// Connection-map register file written one bit per clock.
// Assumes DEPTH < 2**ADDR_W so that out-of-range addresses exist.
// Out-of-range writes are dropped and flagged for one cycle.
module pla_fuse_store #(
    parameter int DEPTH  = 12,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_bit,
    output logic [DEPTH-1:0]  fuse_map,
    output logic              wr_err
);

    logic addr_ok;

    // Decide whether the requested address exists in the map.
    always_comb begin
        addr_ok = (int'(wr_addr) < DEPTH);
    end

    // Store the addressed bit; reset clears the whole map.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fuse_map <= '0;
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                if (wr_en && addr_ok && (int'(wr_addr) == k)) begin
                    fuse_map[k] <= wr_bit;
                end
            end
        end
    end

    // Pulse the error flag for one cycle after a rejected write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_err <= 1'b0;
        end else begin
            wr_err <= wr_en && !addr_ok;
        end
    end

endmodule

// File: rtl/pla_column_tap.sv
`timescale 1ns/1ps
// Picks each gate's connection bits out of the flat map using the
// base + input*IN_STEP + gate*GATE_STEP address rule.
// Assumes every computed address is below DEPTH.
module pla_column_tap #(
    parameter int N_IN      = 3,
    parameter int N_GATE    = 4,
    parameter int DEPTH     = 12,
    parameter bit WITH_COMP = 1'b0,
    parameter int TRUE_BASE = 0,
    parameter int COMP_BASE = 1,
    parameter int IN_STEP   = 1,
    parameter int GATE_STEP = 3
) (
    input  logic [DEPTH-1:0]         fuse_map,
    output logic [N_GATE*N_IN-1:0]   conn_true,
    output logic [N_GATE*N_IN-1:0]   conn_comp
);

    for (genvar g = 0; g < N_GATE; g++) begin : g_gate
        for (genvar i = 0; i < N_IN; i++) begin : g_in
            localparam int TADDR = TRUE_BASE + i*IN_STEP + g*GATE_STEP;
            // True-column connection bit.
            assign conn_true[g*N_IN + i] = fuse_map[TADDR];
            if (WITH_COMP) begin : g_comp
                localparam int CADDR = COMP_BASE + i*IN_STEP + g*GATE_STEP;
                // Complement-column connection bit.
                assign conn_comp[g*N_IN + i] = fuse_map[CADDR];
            end else begin : g_nocomp
                // No complement columns exist in plain mode.
                assign conn_comp[g*N_IN + i] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/pla_gate_eval.sv
`timescale 1ns/1ps
// One output gate: reduces its connected true and complement column
// values with the selected function. Unconnected columns drop out,
// so an empty gate gives the identity value (inverted if required).
module pla_gate_eval #(
    parameter int               N_IN    = 3,
    parameter pla_pkg::gate_fn_e GATE_FN = pla_pkg::FN_OR
) (
    input  logic [N_IN-1:0] a_in,
    input  logic [N_IN-1:0] conn_true,
    input  logic [N_IN-1:0] conn_comp,
    output logic            y
);

    logic red_and, red_or, red_xor, base;

    // Reduce connected literals in the three base forms.
    always_comb begin
        red_and = (&(a_in | ~conn_true)) & (&(~a_in | ~conn_comp));
        red_or  = (|(a_in & conn_true))  | (|(~a_in & conn_comp));
        red_xor = (^(a_in & conn_true))  ^ (^(~a_in & conn_comp));
    end

    // Pick the base form and apply the inversion of the variant.
    always_comb begin
        case (GATE_FN)
            pla_pkg::FN_AND, pla_pkg::FN_NAND: base = red_and;
            pla_pkg::FN_OR,  pla_pkg::FN_NOR:  base = red_or;
            default:                           base = red_xor;
        endcase
        y = base ^ pla_pkg::fn_inverts(GATE_FN);
    end

endmodule

// File: rtl/pla_core.sv
`timescale 1ns/1ps
// Programmable logic array top: serial-written connection map,
// address mapping, and N_GATE combinational gates.
// Assumes the derived map depth fits below 2**ADDR_W.
module pla_core #(
    parameter int                N_IN      = 3,
    parameter int                N_GATE    = 4,
    parameter pla_pkg::gate_fn_e GATE_FN   = pla_pkg::FN_OR,
    parameter bit                WITH_COMP = 1'b0,
    parameter int                TRUE_BASE = 0,
    parameter int                COMP_BASE = 1,
    parameter int                IN_STEP   = WITH_COMP ? 2 : 1,
    parameter int                GATE_STEP = (WITH_COMP ? 2 : 1) * N_IN,
    parameter int                ADDR_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_bit,
    input  logic [N_IN-1:0]   a_in,
    output logic [N_GATE-1:0] y_out,
    output logic              wr_err
);

    localparam int BASE_HI   = (WITH_COMP && (COMP_BASE > TRUE_BASE)) ? COMP_BASE : TRUE_BASE;
    localparam int MAP_DEPTH = BASE_HI + (N_IN-1)*IN_STEP + (N_GATE-1)*GATE_STEP + 1;

    logic [MAP_DEPTH-1:0]     fuse_map;
    logic [N_GATE*N_IN-1:0]   conn_true;
    logic [N_GATE*N_IN-1:0]   conn_comp;

    pla_fuse_store #(
        .DEPTH  (MAP_DEPTH),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_bit   (wr_bit),
        .fuse_map (fuse_map),
        .wr_err   (wr_err)
    );

    pla_column_tap #(
        .N_IN      (N_IN),
        .N_GATE    (N_GATE),
        .DEPTH     (MAP_DEPTH),
        .WITH_COMP (WITH_COMP),
        .TRUE_BASE (TRUE_BASE),
        .COMP_BASE (COMP_BASE),
        .IN_STEP   (IN_STEP),
        .GATE_STEP (GATE_STEP)
    ) u_tap (
        .fuse_map  (fuse_map),
        .conn_true (conn_true),
        .conn_comp (conn_comp)
    );

    for (genvar g = 0; g < N_GATE; g++) begin : g_gate
        pla_gate_eval #(
            .N_IN    (N_IN),
            .GATE_FN (GATE_FN)
        ) u_gate (
            .a_in      (a_in),
            .conn_true (conn_true[g*N_IN +: N_IN]),
            .conn_comp (conn_comp[g*N_IN +: N_IN]),
            .y         (y_out[g])
        );
    end

endmodule

// File: rtl/pla_core_chk.sv
`timescale 1ns/1ps
// Assertion checker for pla_core, attached by bind.
// Observes the write port, the stored map and the gate outputs.
module pla_core_chk #(
    parameter int                N_GATE  = 4,
    parameter int                ADDR_W  = 6,
    parameter int                DEPTH   = 12,
    parameter pla_pkg::gate_fn_e GATE_FN = pla_pkg::FN_OR
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_bit,
    input logic [N_GATE-1:0] y_out,
    input logic              wr_err,
    input logic [DEPTH-1:0]  fuse_map
);

    // R1: map is empty on the first edge after reset release.
    p_reset_clear_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (fuse_map == '0));

    // R2: an in-range write lands at its address.
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_addr) < DEPTH)) |=>
        ((|((fuse_map >> $past(wr_addr)) & DEPTH'(1))) == $past(wr_bit)));

    // R8: with an empty map every gate shows its identity level.
    p_empty_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_map == '0) |-> (y_out == {N_GATE{pla_pkg::empty_level(GATE_FN)}}));

    // R9: an out-of-range write leaves the map unchanged.
    p_bad_write_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_addr) >= DEPTH)) |=> $stable(fuse_map));

    // R9: an out-of-range write raises the flag next cycle.
    p_err_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_addr) >= DEPTH)) |=> wr_err);

    // R9: without a write there is no flag next cycle.
    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !wr_err);

endmodule

bind pla_core pla_core_chk #(
    .N_GATE  (N_GATE),
    .ADDR_W  (ADDR_W),
    .DEPTH   (MAP_DEPTH),
    .GATE_FN (GATE_FN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_bit   (wr_bit),
    .y_out    (y_out),
    .wr_err   (wr_err),
    .fuse_map (fuse_map)
);

// File: tb/pla_core_test.sv
`timescale 1ns/1ps
// Bench: three array configurations, exhaustive input sweeps after
// each map load, expected outputs computed from the address rules.
module pla_core_test;

    localparam int NI = 3;
    localparam int NG = 4;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    wen = '0;
    logic [AW-1:0] wr_addr = '0;
    logic          wr_bit = 1'b0;
    logic [NI-1:0] a_in = '0;
    logic [NG-1:0] y0, y1, y2;
    logic          e0, e1, e2;

    int n_vec = 0;
    int n_bad = 0;

    // Connection arrays kept by the bench: [unit][gate][input].
    bit ct [3][NG][NI];
    bit cc [3][NG][NI];

    always #2.5 clk = ~clk;

    // Unit 0: plain OR, default mapping (depth 12).
    pla_core #(.N_IN(NI), .N_GATE(NG), .GATE_FN(pla_pkg::FN_OR),
               .WITH_COMP(1'b0), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wen[0]), .wr_addr(wr_addr),
        .wr_bit(wr_bit), .a_in(a_in), .y_out(y0), .wr_err(e0));

    // Unit 1: paired XNOR, default mapping (depth 24).
    pla_core #(.N_IN(NI), .N_GATE(NG), .GATE_FN(pla_pkg::FN_XNOR),
               .WITH_COMP(1'b1), .ADDR_W(AW)) uut_x (
        .clk(clk), .rst_n(rst_n), .wr_en(wen[1]), .wr_addr(wr_addr),
        .wr_bit(wr_bit), .a_in(a_in), .y_out(y1), .wr_err(e1));

    // Unit 2: plain NAND, base 2, gate stride 5 (depth 20).
    pla_core #(.N_IN(NI), .N_GATE(NG), .GATE_FN(pla_pkg::FN_NAND),
               .WITH_COMP(1'b0), .TRUE_BASE(2), .IN_STEP(1), .GATE_STEP(5),
               .ADDR_W(AW)) uut_n (
        .clk(clk), .rst_n(rst_n), .wr_en(wen[2]), .wr_addr(wr_addr),
        .wr_bit(wr_bit), .a_in(a_in), .y_out(y2), .wr_err(e2));

    // Expected gate output from the function requirements (R5..R8).
    function automatic bit expect_gate(int u, int g, logic [NI-1:0] a);
        bit r_and = 1'b1, r_or = 1'b0, r_xor = 1'b0;
        for (int i = 0; i < NI; i++) begin
            if (ct[u][g][i]) begin
                r_and &= a[i]; r_or |= a[i]; r_xor ^= a[i];
            end
            if (cc[u][g][i]) begin
                r_and &= ~a[i]; r_or |= ~a[i]; r_xor ^= ~a[i];
            end
        end
        case (u)
            0:       return r_or;
            1:       return ~r_xor;
            default: return ~r_and;
        endcase
    endfunction

    task automatic check(string tag, logic [NG-1:0] act, logic [NG-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic put(int u, int addr, bit b);
        @(negedge clk);
        wr_addr = AW'(addr);
        wr_bit  = b;
        wen     = 3'b001 << u;
        @(negedge clk);
        wen     = '0;
    endtask

    // Write every mapped bit of all units (R2, R3, R4 addressing).
    task automatic load_all();
        for (int g = 0; g < NG; g++) begin
            for (int i = 0; i < NI; i++) begin
                put(0, i + g*NI, ct[0][g][i]);
                put(1, 2*i + g*2*NI, ct[1][g][i]);
                put(1, 1 + 2*i + g*2*NI, cc[1][g][i]);
                put(2, 2 + i + g*5, ct[2][g][i]);
            end
        end
    endtask

    // Sweep all inputs; samples land between edges (R10).
    task automatic sweep(string tag);
        for (int a = 0; a < (1 << NI); a++) begin
            @(negedge clk);
            a_in = NI'(a);
            #1;
            for (int u = 0; u < 3; u++) begin
                logic [NG-1:0] exp;
                for (int g = 0; g < NG; g++) exp[g] = expect_gate(u, g, a_in);
                case (u)
                    0: check({tag, " R6 R3 R10 unit0"}, y0, exp);
                    1: check({tag, " R7 R4 unit1"},     y1, exp);
                    default: check({tag, " R5 R3 unit2"}, y2, exp);
                endcase
            end
        end
    endtask

    task automatic fill(int mode);
        for (int u = 0; u < 3; u++)
            for (int g = 0; g < NG; g++)
                for (int i = 0; i < NI; i++) begin
                    ct[u][g][i] = (mode == 1) ? 1'b1 : (mode == 0) ? 1'b0 : 1'($urandom);
                    cc[u][g][i] = (u != 1) ? 1'b0 :
                                  (mode == 1) ? 1'b1 : (mode == 0) ? 1'b0 : 1'($urandom);
                end
    endtask

    initial begin
        fill(0);
        repeat (3) @(negedge clk);
        // R1/R8: reset state, empty gates: OR 0, XNOR 1, NAND 0.
        check("R1 reset wr_err", {3'b000, e0}, {3'b000, 1'b0});
        sweep("R1 R8 reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        sweep("R8 empty after release");

        // R2: all-ones map.
        fill(1); load_all(); sweep("R2 ones");

        // R11: example map on unit 0.
        fill(0);
        ct[0][0] = '{1, 1, 1}; ct[0][1] = '{0, 1, 0};
        ct[0][2] = '{1, 0, 1}; ct[0][3] = '{0, 0, 1};
        load_all();
        for (int a = 0; a < 8; a++) begin
            logic [2:0] v;
            @(negedge clk);
            a_in = 3'(a);
            v = 3'(a);
            #1;
            check("R11 example", y0, {v[2], v[0] | v[2], v[1], |v});
        end
        sweep("R11 generic");

        // R9: writes past the end of unit 0 are dropped and flagged.
        @(negedge clk);
        a_in = 3'b111;
        wr_addr = AW'(12); wr_bit = 1'b1; wen = 3'b001;
        @(negedge clk);
        wen = '0;
        check("R9 err pulse", {3'b000, e0}, 4'b0001);
        @(negedge clk);
        check("R9 err cleared", {3'b000, e0}, 4'b0000);
        check("R9 map unchanged", y0, 4'b1111);
        put(0, 63, 1'b1);
        check("R9 err top addr", {3'b000, e0}, 4'b0001);
        sweep("R9 after bad writes");

        // R2: clearing bits back to 0 disconnects them.
        fill(0); load_all(); sweep("R2 cleared");

        // Pseudo-random maps.
        for (int p = 0; p < 12; p++) begin
            fill(2); load_all(); sweep("R2 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(200000 * 5);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule